// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator with NMI Routing

This block sits between a set of peripheral interrupt sources and a processor's interrupt controller. Every source bit passes through a two-flop synchronizer. The synchronized sub-source bits that belong to one interrupt line are ORed into that line's level. The line levels are ORed with a software-owned test vector and then drive a parallel IRQ output vector. Some lines are shared by several sub-sources. For each line, a read-only identity register shows which of its sub-sources is active. Lines that carry no source have a plain read-write scratch word at the same place in the map.

One selected line can also be routed to a non-maskable interrupt output. The line is chosen by a 5-bit index, and the route is opened by an enable bit. That enable bit can only be changed after a three-byte key sequence has been written to a separate key port, which stands in for a system lock controller.

Software reaches the block through a word-addressed bus with separate read and write strobes. Word n, for n from 0 to 31, is the identity register of line n. Word 32 is the NMI control. Word 33 is the IRQ vector. Word 34 and above lie outside the 0x88-byte window.

Top module: `irq_hub`

## Requirements
- R1: After reset, the IRQ vector and the NMI output are 0, every register reads 0, and the key lock is closed.
- R2: A sub-source input bit that changes before clock edge k shows on the IRQ output after edge k+1 (two-flop synchronizer). A line's level is the OR of its own synchronized sub-source bits.
- R3: A read of word n for a populated line returns its synchronized sub-source levels in the low bits, zero-extended. Line 1 uses bits 0 and 1. Line 4 uses bits 0 and 1. Line 5 uses bits 0 to 2. Lines 0, 2, 3, 6 to 9, 12 to 14, 16 to 19, 25, 28 and 29 use bit 0 only. Sub-source input bit s of line n is input bit 4*n+s. Input bits that are not mapped are ignored, and writes to these words have no effect.
- R4: For an unpopulated line (10, 11, 15, 20 to 24, 26, 27, 30, 31), word n is a 32-bit read-write store that resets to 0, and the inputs of that line never reach the IRQ output.
- R5: Writing word 33 with bit n set while the software bit n is 0 sets that software bit and raises IRQ output n.
- R6: Writing word 33 with bit n set while the software bit n is 1 clears that software bit. Data bits that are 0 leave their software bits unchanged.
- R7: IRQ output n is the OR of line n's level and software bit n. A read of word 33 returns the IRQ output vector.
- R8: Word 32 holds the line select in bits 4:0 and the NMI enable in bit 8. The NMI output equals the IRQ output bit of the selected line ANDed with the enable.
- R9: Writes to word 32 always update the select. They update the enable only while the lock is open.
- R10: The lock opens only after the key port receives the bytes 0x59, 0x16 and 0x88 in consecutive key writes. Any byte out of this order returns the detector to its start.
- R11: While the lock is open, any key write closes it again.
- R12: Reads of word 34 and above return 0, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphSrc | input | 128 | Raw sub-source interrupt bits, 4 per line (bit 4*n+s) |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe |
| wordAddr | input | 6 | Word index (byte offset / 4) |
| wrData | input | 32 | Bus write data |
| rdData | output | 32 | Bus read data, registered one cycle after rdEn |
| keyWrEn | input | 1 | Key port write strobe |
| keyData | input | 8 | Key byte |
| irqOut | output | 32 | IRQ vector to the interrupt controller |
| nmiOut | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with its default parameters: 32 lines, 4 sub-source bits per line, and the default sub-source map. This map mixes single-source, two-source and three-source lines with unpopulated lines. With these values the bench can reach the scratch-store path, the ignored unmapped input bits and the full 5-bit select range. A behavioural model with a two-entry queue for the synchronizer tracks the IRQ vector and the NMI output on every clock. Scripted register reads check the identity, lock and out-of-window behaviour.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int DefLines = 32;
  localparam int DefSubW  = 4;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic wrIdent;
    logic wrNmi;
    logic wrVec;
    logic rdIdent;
    logic rdNmi;
    logic rdVec;
    logic rdZero;
    logic nmiEnOk;
  } hubStrobe_t;

  // Default sub-source map: a set bit marks a live sub-source of a line.
  function automatic logic [DefLines*DefSubW-1:0] defaultSubMap();
    logic [DefLines*DefSubW-1:0] m;
    m = '0;
    for (int n = 0; n < DefLines; n++) begin
      case (n)
        1, 4:    m[n*DefSubW +: DefSubW] = DefSubW'(3);
        5:       m[n*DefSubW +: DefSubW] = DefSubW'(7);
        0, 2, 3, 6, 7, 8, 9, 12, 13, 14, 16, 17, 18, 19, 25, 28, 29:
                 m[n*DefSubW +: DefSubW] = DefSubW'(1);
        default: m[n*DefSubW +: DefSubW] = '0;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 6,
  parameter logic [7:0] KEY0 = 8'h59,
  parameter logic [7:0] KEY1 = 8'h16,
  parameter logic [7:0] KEY2 = 8'h88
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              keyWrEn,
  input  logic [7:0]        keyData,
  output hubStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] NMI_WORD = ADDR_W'(NUM_LINES);
  localparam logic [ADDR_W-1:0] VEC_WORD = ADDR_W'(NUM_LINES + 1);

  typedef enum logic [1:0] {LK_IDLE, LK_K1, LK_K2, LK_OPEN} lockState_t;

  lockState_t lockQ, lockD;
  logic isIdent, isNmi, isVec, lockOpen;

  always_comb begin
    isIdent = wordAddr < NMI_WORD;
    isNmi   = wordAddr == NMI_WORD;
    isVec   = wordAddr == VEC_WORD;
    strb.wrIdent = wrEn & isIdent;
    strb.wrNmi   = wrEn & isNmi;
    strb.wrVec   = wrEn & isVec;
    strb.rdIdent = rdEn & isIdent;
    strb.rdNmi   = rdEn & isNmi;
    strb.rdVec   = rdEn & isVec;
    strb.rdZero  = rdEn & ~(isIdent | isNmi | isVec);
    strb.nmiEnOk = lockOpen;
  end

  assign lockOpen = (lockQ == LK_OPEN);

  // Key sequence detector: strict order, any stray byte restarts it.
  always_comb begin
    lockD = lockQ;
    if (keyWrEn) begin
      unique case (lockQ)
        LK_IDLE: lockD = (keyData == KEY0) ? LK_K1   : LK_IDLE;
        LK_K1:   lockD = (keyData == KEY1) ? LK_K2   : LK_IDLE;
        LK_K2:   lockD = (keyData == KEY2) ? LK_OPEN : LK_IDLE;
        LK_OPEN: lockD = LK_IDLE;
        default: lockD = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= LK_IDLE;
    else       lockQ <= lockD;
  end

  assert_open_after_key_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOpen) |-> $past(keyWrEn && keyData == KEY2));

  assert_relock_R11: assert property (@(posedge clk) disable iff (!rstN)
    (lockOpen && keyWrEn) |=> !lockOpen);

  assert_outside_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordAddr > VEC_WORD) |-> !(strb.wrIdent || strb.wrNmi || strb.wrVec));

endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int SUB_W      = 4,
  parameter int DATA_W     = 32,
  parameter int NMI_EN_BIT = 8,
  parameter logic [NUM_LINES*SUB_W-1:0] SUB_MAP = defaultSubMap(),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int SRC_W  = NUM_LINES * SUB_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hubStrobe_t           strb,
  input  logic [LINE_W-1:0]    lineIdx,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [SRC_W-1:0]     periphSrc,
  output logic [NUM_LINES-1:0] irqOut,
  output logic                 nmiOut,
  output logic [DATA_W-1:0]    rdData
);

  logic [SRC_W-1:0]     syncA, syncB, maskedSrc;
  logic [NUM_LINES-1:0] lineLvl, swIrq;
  logic [LINE_W-1:0]    nmiSel;
  logic                 nmiEn;
  logic [DATA_W-1:0]    nmiWord;
  logic [DATA_W-1:0]    identRd [NUM_LINES];

  function automatic logic [NUM_LINES-1:0] reduceLines(input logic [SRC_W-1:0] v);
    logic [NUM_LINES-1:0] r;
    for (int n = 0; n < NUM_LINES; n++) r[n] = |v[n*SUB_W +: SUB_W];
    return r;
  endfunction

  // Two-flop synchronizer on every sub-source bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= periphSrc;
      syncB <= syncA;
    end
  end

  assign maskedSrc = syncB & SUB_MAP;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    assign lineLvl[n] = |maskedSrc[n*SUB_W +: SUB_W];
    if (|SUB_MAP[n*SUB_W +: SUB_W]) begin : g_live
      assign identRd[n] = DATA_W'(maskedSrc[n*SUB_W +: SUB_W]);
    end else begin : g_spare
      logic [DATA_W-1:0] spareQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) spareQ <= '0;
        else if (strb.wrIdent && lineIdx == LINE_W'(n)) spareQ <= wrData;
      end
      assign identRd[n] = spareQ;
    end
  end

  // Software test vector and NMI control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swIrq  <= '0;
      nmiSel <= '0;
      nmiEn  <= 1'b0;
    end else begin
      if (strb.wrVec) swIrq <= swIrq ^ wrData[NUM_LINES-1:0];
      if (strb.wrNmi) begin
        nmiSel <= wrData[LINE_W-1:0];
        if (strb.nmiEnOk) nmiEn <= wrData[NMI_EN_BIT];
      end
    end
  end

  assign irqOut = lineLvl | swIrq;
  assign nmiOut = nmiEn & irqOut[nmiSel];

  always_comb begin
    nmiWord = '0;
    nmiWord[LINE_W-1:0] = nmiSel;
    nmiWord[NMI_EN_BIT] = nmiEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strb.rdIdent) rdData <= identRd[lineIdx];
    else if (strb.rdNmi)   rdData <= nmiWord;
    else if (strb.rdVec)   rdData <= DATA_W'(irqOut);
    else if (strb.rdZero)  rdData <= '0;
  end

  // Cycles since reset, so the synchronizer check never looks before reset
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  assert_sync_depth_R2: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2) |-> lineLvl == reduceLines($past(periphSrc, 2) & SUB_MAP));

  assert_vec_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrVec |=> $stable(swIrq));

  assert_enable_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (nmiEn != $past(nmiEn)) |-> $past(strb.nmiEnOk && strb.wrNmi));

  assert_outside_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdZero |=> rdData == '0);

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int SUB_W      = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int NMI_EN_BIT = 8,
  parameter logic [NUM_LINES*SUB_W-1:0] SUB_MAP = defaultSubMap(),
  parameter logic [7:0] KEY0 = 8'h59,
  parameter logic [7:0] KEY1 = 8'h16,
  parameter logic [7:0] KEY2 = 8'h88
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_LINES*SUB_W-1:0] periphSrc,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [ADDR_W-1:0]          wordAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  input  logic                       keyWrEn,
  input  logic [7:0]                 keyData,
  output logic [NUM_LINES-1:0]       irqOut,
  output logic                       nmiOut
);

  localparam int LINE_W = $clog2(NUM_LINES);

  hubStrobe_t strb;

  irq_hub_ctrl #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
    .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wordAddr(wordAddr),
    .keyWrEn(keyWrEn), .keyData(keyData), .strb(strb)
  );

  irq_hub_dp #(
    .NUM_LINES(NUM_LINES), .SUB_W(SUB_W), .DATA_W(DATA_W),
    .NMI_EN_BIT(NMI_EN_BIT), .SUB_MAP(SUB_MAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lineIdx(wordAddr[LINE_W-1:0]),
    .wrData(wrData), .periphSrc(periphSrc), .irqOut(irqOut),
    .nmiOut(nmiOut), .rdData(rdData)
  );

endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] src = '0;
  logic         wrEn = 1'b0, rdEn = 1'b0, keyWrEn = 1'b0;
  logic [5:0]   wordAddr = '0;
  logic [31:0]  wrData = '0;
  logic [7:0]   keyData = '0;
  logic [31:0]  rdData;
  logic [31:0]  irqOut;
  logic         nmiOut;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub i_irq_hub (
    .clk(clk), .rstN(rstN), .periphSrc(src), .wrEn(wrEn), .rdEn(rdEn),
    .wordAddr(wordAddr), .wrData(wrData), .rdData(rdData),
    .keyWrEn(keyWrEn), .keyData(keyData), .irqOut(irqOut), .nmiOut(nmiOut)
  );

  // ---------------- reference model ----------------
  function automatic logic [3:0] subMask(int n);
    case (n)
      1, 4: return 4'b0011;
      5:    return 4'b0111;
      0, 2, 3, 6, 7, 8, 9, 12, 13, 14, 16, 17, 18, 19, 25, 28, 29: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] lineLevels(logic [127:0] v);
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[n] = |(v[n*4 +: 4] & subMask(n));
    return r;
  endfunction

  logic [127:0] q[$];
  logic [31:0]  mSw = '0;
  logic [4:0]   mSel = '0;
  bit           mEn = 0, mOpen = 0, started = 0;
  int           mStage = 0;

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      q = {128'h0, 128'h0};
      mSw = '0; mSel = '0; mEn = 0; mOpen = 0; mStage = 0;
    end else begin
      if (wrEn && wordAddr == 6'd32) begin
        mSel = wrData[4:0];
        if (mOpen) mEn = wrData[8];
      end
      if (wrEn && wordAddr == 6'd33) mSw = mSw ^ wrData;
      if (keyWrEn) begin
        if (mOpen) begin mOpen = 0; mStage = 0; end
        else if (mStage == 0) mStage = (keyData == 8'h59) ? 1 : 0;
        else if (mStage == 1) mStage = (keyData == 8'h16) ? 2 : 0;
        else begin
          if (keyData == 8'h88) mOpen = 1;
          mStage = 0;
        end
      end
      q.push_back(src);
      void'(q.pop_front());
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison of the IRQ vector (R7, R2) and NMI output (R8)
  always @(negedge clk) begin
    if (started && q.size() == 2) begin
      logic [31:0] expIrq;
      expIrq = lineLevels(q[0]) | mSw;
      check(irqOut === expIrq, rstN ? "R7 irq vector" : "R1 irq in reset", irqOut, expIrq);
      check(nmiOut === (mEn & expIrq[mSel]), "R8 nmi output",
            {31'b0, nmiOut}, {31'b0, mEn & expIrq[mSel]});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic busWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; wordAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic busRead(logic [5:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rdEn = 1; wordAddr = a;
    @(negedge clk); rdEn = 0;
    check(rdData === exp, tag, rdData, exp);
  endtask

  task automatic keyWrite(logic [7:0] b);
    @(negedge clk); keyWrEn = 1; keyData = b;
    @(negedge clk); keyWrEn = 0;
  endtask

  task automatic setSrc(logic [127:0] v);
    @(negedge clk); src = v;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [127:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    busRead(6'd0, 32'h0, "R1 ident 0 after reset");
    busRead(6'd32, 32'h0, "R1 nmi control after reset");
    busRead(6'd33, 32'h0, "R1 vector after reset");
    busRead(6'd10, 32'h0, "R1 spare word after reset");
    // lock closed after reset: enable write refused
    busWrite(6'd32, 32'h100);
    busRead(6'd32, 32'h0, "R1 lock closed after reset");

    // R3 / R4 sub-sources: line0 b0, line1 b0+b1, line4 unmapped b2, line5 b2, line10 b0
    v = '0;
    v[0] = 1; v[4] = 1; v[5] = 1; v[18] = 1; v[22] = 1; v[40] = 1;
    setSrc(v); settle();
    busRead(6'd1, 32'h3, "R3 line1 two sub-sources");
    busRead(6'd5, 32'h4, "R3 line5 sub-source 2");
    busRead(6'd4, 32'h0, "R3 line4 unmapped bit ignored");
    busRead(6'd0, 32'h1, "R3 line0 single source");
    busRead(6'd33, 32'h23, "R4 unused line10 input ignored");

    // R2 synchronizer latency on line 8
    v[32] = 1;
    setSrc(v);
    @(negedge clk); check(irqOut[8] === 1'b0, "R2 one edge: not yet", {31'b0, irqOut[8]}, 32'h0);
    @(negedge clk); check(irqOut[8] === 1'b1, "R2 two edges: visible", {31'b0, irqOut[8]}, 32'h1);

    // R3 write to identity word ignored
    busWrite(6'd1, 32'hFFFF_FFFF);
    busRead(6'd1, 32'h3, "R3 write to identity ignored");

    // R4 spare storage
    busWrite(6'd10, 32'hDEAD_BEEF);
    busRead(6'd10, 32'hDEAD_BEEF, "R4 spare line10 storage");
    busWrite(6'd31, 32'h1234_5678);
    busRead(6'd31, 32'h1234_5678, "R4 spare line31 storage");
    busRead(6'd11, 32'h0, "R4 spare line11 untouched");

    // R5 / R6 software vector
    setSrc('0); settle();
    busWrite(6'd33, 32'h0000_0101);
    busRead(6'd33, 32'h101, "R5 write one sets bits");
    busWrite(6'd33, 32'h0000_0001);
    busRead(6'd33, 32'h100, "R6 write one clears set bit");
    busWrite(6'd33, 32'h0);
    busRead(6'd33, 32'h100, "R6 write zero no effect");
    busWrite(6'd33, 32'h100);
    busRead(6'd33, 32'h0, "R6 clear last bit");

    // R7 OR of peripheral line and software bit
    v = '0; v[32] = 1;
    setSrc(v); settle();
    busRead(6'd33, 32'h100, "R7 peripheral only");
    busWrite(6'd33, 32'h100);
    busRead(6'd33, 32'h100, "R7 both set");
    setSrc('0); settle();
    busRead(6'd33, 32'h100, "R7 software keeps line");
    busWrite(6'd33, 32'h100);
    busRead(6'd33, 32'h0, "R7 both clear");

    // R9 locked: select written, enable refused
    busWrite(6'd32, 32'h105);
    busRead(6'd32, 32'h5, "R9 enable refused while locked");

    // R10 out-of-order keys
    keyWrite(8'h59); keyWrite(8'h88); keyWrite(8'h16);
    busWrite(6'd32, 32'h105);
    busRead(6'd32, 32'h5, "R10 wrong order keeps lock");
    keyWrite(8'h59); keyWrite(8'h16); keyWrite(8'h59); keyWrite(8'h88);
    busWrite(6'd32, 32'h105);
    busRead(6'd32, 32'h5, "R10 broken sequence keeps lock");

    // R10 correct sequence opens lock
    keyWrite(8'h59); keyWrite(8'h16); keyWrite(8'h88);
    busWrite(6'd32, 32'h105);
    busRead(6'd32, 32'h105, "R10 unlocked enable write");

    // R8 routing
    v = '0; v[20] = 1;
    setSrc(v); settle();
    check(nmiOut === 1'b1, "R8 selected line routed", {31'b0, nmiOut}, 32'h1);
    busWrite(6'd32, 32'h103);
    check(nmiOut === 1'b0, "R8 other line selected", {31'b0, nmiOut}, 32'h0);
    busWrite(6'd32, 32'h105);
    check(nmiOut === 1'b1, "R8 reselected", {31'b0, nmiOut}, 32'h1);

    // R11 relock on any key write
    keyWrite(8'h00);
    busWrite(6'd32, 32'h004);
    busRead(6'd32, 32'h104, "R11 relocked enable kept");

    // R12 out of window
    busWrite(6'd40, 32'hFFFF_FFFF);
    busRead(6'd34, 32'h0, "R12 word 34 reads zero");
    busRead(6'd40, 32'h0, "R12 word 40 reads zero");
    busRead(6'd63, 32'h0, "R12 word 63 reads zero");
    busRead(6'd33, 32'h20, "R12 vector untouched");
    busRead(6'd32, 32'h104, "R12 nmi control untouched");

    setSrc('0); settle();
    summary();
  end

endmodule